// File: doc/BRIEF.md
# UART Register and FIFO Front-End

This block is the software-visible front of a simple serial port. A 32-bit bus reaches a small set of word registers. Through them it sets the line mode and the two baud-rate settings, enables or resets the transmit and receive paths independently, and exchanges characters with two 8-bit character FIFOs. The bus signals are an address, a write strobe, a read strobe and the data words.

On the line side the transmit FIFO feeds an external transmit shifter through a valid/ready byte stream. An external receive shifter delivers bytes into the receive FIFO through a second valid/ready stream. The mode word and both baud settings are driven out continuously to the shifters and the baud generator.

Software writes a character to the data register to queue it and reads the same register to take the oldest received character. Software polls the status register for "receive empty" and "transmit full" before each of these accesses. Read data appears on the cycle after the read strobe and is held until the next read.

Top module: `uart_csr_front`

## Requirements
- R1: After reset both FIFOs are empty, both paths are disabled, `tx_valid` and `rx_ready` are 0, the mode register holds 0x020, the baud generator holds 0x028B and the baud divider holds 0x06.
- R2: Registers decode at these byte offsets: control 0x00, mode 0x04, baud generator 0x18, status 0x2C, data 0x30 and baud divider 0x34. Any other address reads 0, and a write to it changes nothing.
- R3: Control bit 2 enables the receiver and control bit 4 enables the transmitter. Both bits read back as written, and every other control bit reads 0.
- R4: A control write with bit 1 set empties the transmit FIFO, and one with bit 0 set empties the receive FIFO. The FIFO is empty in the next cycle and the bit always reads 0. The enable bits take the value written in the same word.
- R5: Status bit 1 reads 1 when the receive FIFO is empty, and status bit 4 reads 1 when the transmit FIFO is full. All other status bits read 0.
- R6: A data-register write pushes bits 7:0 into the transmit FIFO in order. A write while the transmit FIFO is full is dropped.
- R7: A data-register read returns the oldest receive byte in bits 7:0, with zero upper bits, and pops it. A read while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R8: `tx_valid` is high only while the transmitter is enabled and the transmit FIFO holds a byte. A byte leaves in FIFO order on each cycle with `tx_valid` and `tx_ready` both high.
- R9: `rx_ready` is high only while the receiver is enabled and the receive FIFO is not full. A byte is stored on each cycle with `rx_valid` and `rx_ready` both high.
- R10: The mode register keeps 11 bits (bits 10:0). Upper bits read 0, and the stored value drives `line_mode`.
- R11: The baud generator keeps 16 bits and the baud divider keeps 8 bits. Both read back with zero upper bits and drive `baud_gen` and `baud_div`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the read strobe |
| tx_data | output | 8 | Byte offered to the transmit shifter |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmit shifter takes the byte |
| rx_data | input | 8 | Byte from the receive shifter |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte can be stored |
| line_mode | output | 11 | Stored mode word |
| baud_gen | output | 16 | Baud generator setting |
| baud_div | output | 8 | Baud divider setting |

## Verification
The embedded properties watch the stream gating on every cycle: no transmit offer while the transmitter is disabled, and no receive acceptance while the receiver is disabled. They also check that a reset bit leaves its FIFO empty one cycle later, that neither FIFO passes its depth or changes on a dropped push or an empty pop, and that status, control and empty-data reads return the expected bits.

Only the bench scenarios can show byte ordering through both FIFOs, the reset values, the register widths and the masking of upper bits. The same holds for the silence of reserved addresses and for the byte dropped on a full FIFO, which becomes visible only after the surviving bytes have been drained.

// File: rtl/uart_front_pkg.sv
package uart_front_pkg;
   localparam int unsigned BUS_W = 32;

   localparam logic [7:0] OFS_CTRL = 8'h00;
   localparam logic [7:0] OFS_MODE = 8'h04;
   localparam logic [7:0] OFS_BGEN = 8'h18;
   localparam logic [7:0] OFS_STAT = 8'h2C;
   localparam logic [7:0] OFS_DATA = 8'h30;
   localparam logic [7:0] OFS_BDIV = 8'h34;

   localparam int unsigned CTRL_RXRST = 0;
   localparam int unsigned CTRL_TXRST = 1;
   localparam int unsigned CTRL_RXEN  = 2;
   localparam int unsigned CTRL_TXEN  = 4;

   localparam int unsigned STAT_RXEMPTY = 1;
   localparam int unsigned STAT_TXFULL  = 4;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_MODE,
      SEL_BGEN,
      SEL_STAT,
      SEL_DATA,
      SEL_BDIV
   } reg_sel_e;
endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
   import uart_front_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("uart_addr_dec: ADDR_W must cover offset 0x34");
   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] A_BGEN = ADDR_W'(OFS_BGEN);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_BDIV = ADDR_W'(OFS_BDIV);

   always_comb begin
      sel = SEL_NONE;
      if (addr == A_CTRL)      sel = SEL_CTRL;
      else if (addr == A_MODE) sel = SEL_MODE;
      else if (addr == A_BGEN) sel = SEL_BGEN;
      else if (addr == A_STAT) sel = SEL_STAT;
      else if (addr == A_DATA) sel = SEL_DATA;
      else if (addr == A_BDIV) sel = SEL_BDIV;
   end
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
   import uart_front_pkg::*;
#(
   parameter int unsigned       MODE_W   = 11,
   parameter logic [MODE_W-1:0] MODE_RST = MODE_W'(11'h020),
   parameter int unsigned       BGEN_W   = 16,
   parameter logic [BGEN_W-1:0] BGEN_RST = BGEN_W'(16'h028B),
   parameter int unsigned       BDIV_W   = 8,
   parameter logic [BDIV_W-1:0] BDIV_RST = BDIV_W'(8'h06)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [BUS_W-1:0]  wdata,
   output logic              tx_en,
   output logic              rx_en,
   output logic              tx_flush,
   output logic              rx_flush,
   output logic [MODE_W-1:0] mode,
   output logic [BGEN_W-1:0] bgen,
   output logic [BDIV_W-1:0] bdiv
);
   if (MODE_W > BUS_W || BGEN_W > BUS_W || BDIV_W > BUS_W) begin : g_bad_w
      $error("uart_cfg_regs: register wider than the bus");
   end

   logic ctrl_wr;
   assign ctrl_wr  = wr_en && (sel == SEL_CTRL);
   // reset bits are pulses only; nothing stores them
   assign tx_flush = ctrl_wr && wdata[CTRL_TXRST];
   assign rx_flush = ctrl_wr && wdata[CTRL_RXRST];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en <= 1'b0;
         rx_en <= 1'b0;
         mode  <= MODE_RST;
         bgen  <= BGEN_RST;
         bdiv  <= BDIV_RST;
      end else if (wr_en) begin
         unique case (sel)
            SEL_CTRL: begin
               tx_en <= wdata[CTRL_TXEN];
               rx_en <= wdata[CTRL_RXEN];
            end
            SEL_MODE: mode <= wdata[MODE_W-1:0];
            SEL_BGEN: bgen <= wdata[BGEN_W-1:0];
            SEL_BDIV: bdiv <= wdata[BDIV_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   if (DEPTH < 1 || DEPTH > 1024) begin : g_bad_depth
      $error("uart_byte_fifo: DEPTH out of range");
   end

   localparam int unsigned CW = $clog2(DEPTH + 1);
   logic [CW-1:0] count;

   if (DEPTH == 1) begin : g_single
      logic             hold_q;
      logic [WIDTH-1:0] data_q;
      always_ff @(posedge clk) begin
         if (!rst_n || flush) hold_q <= 1'b0;
         else if (push && !hold_q) hold_q <= 1'b1;
         else if (pop && hold_q) hold_q <= 1'b0;
      end
      always_ff @(posedge clk) begin
         if (push && !hold_q) data_q <= din;
      end
      assign count = CW'(hold_q);
      assign dout  = data_q;
   end else begin : g_ring
      localparam int unsigned AW = $clog2(DEPTH);
      logic [WIDTH-1:0] mem [DEPTH];
      logic [AW-1:0]    rd_ptr, wr_ptr;
      logic [CW-1:0]    cnt_q;
      logic             do_push, do_pop;

      assign do_push = push && (cnt_q != CW'(DEPTH));
      assign do_pop  = pop && (cnt_q != '0);

      function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
         return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk) begin
         if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
         end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
         end
      end
      always_ff @(posedge clk) begin
         if (do_push) mem[wr_ptr] <= din;
      end
      assign count = cnt_q;
      assign dout  = mem[rd_ptr];
   end

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !flush) |=> empty);
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
   import uart_front_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CHAR_W   = 8,
   parameter int unsigned TX_DEPTH = 8,
   parameter int unsigned RX_DEPTH = 8,
   parameter int unsigned MODE_W   = 11,
   parameter int unsigned BGEN_W   = 16,
   parameter int unsigned BDIV_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [CHAR_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [MODE_W-1:0] line_mode,
   output logic [BGEN_W-1:0] baud_gen,
   output logic [BDIV_W-1:0] baud_div
);
   if (CHAR_W > BUS_W) begin : g_bad_char
      $error("uart_csr_front: CHAR_W wider than the bus");
   end

   reg_sel_e          sel;
   logic              tx_en, rx_en, tx_flush, rx_flush;
   logic              tx_empty, tx_full, rx_empty, rx_full;
   logic [CHAR_W-1:0] rx_head;
   logic              host_push, host_pop;
   logic [BUS_W-1:0]  rd_word;

   uart_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));

   uart_cfg_regs #(
      .MODE_W(MODE_W), .BGEN_W(BGEN_W), .BDIV_W(BDIV_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
      .tx_en(tx_en), .rx_en(rx_en), .tx_flush(tx_flush), .rx_flush(rx_flush),
      .mode(line_mode), .bgen(baud_gen), .bdiv(baud_div)
   );

   assign host_push = bus_wr && (sel == SEL_DATA) && !tx_full;
   assign host_pop  = bus_rd && (sel == SEL_DATA) && !rx_empty;
   assign tx_valid  = tx_en && !tx_empty;
   assign rx_ready  = rx_en && !rx_full;

   uart_byte_fifo #(.WIDTH(CHAR_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(host_push), .din(bus_wdata[CHAR_W-1:0]),
      .pop(tx_valid && tx_ready), .dout(tx_data),
      .empty(tx_empty), .full(tx_full)
   );

   uart_byte_fifo #(.WIDTH(CHAR_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_valid && rx_ready), .din(rx_data),
      .pop(host_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   always_comb begin
      rd_word = '0;
      unique case (sel)
         SEL_CTRL: begin
            rd_word[CTRL_TXEN] = tx_en;
            rd_word[CTRL_RXEN] = rx_en;
         end
         SEL_MODE: rd_word[MODE_W-1:0] = line_mode;
         SEL_BGEN: rd_word[BGEN_W-1:0] = baud_gen;
         SEL_BDIV: rd_word[BDIV_W-1:0] = baud_div;
         SEL_STAT: begin
            rd_word[STAT_RXEMPTY] = rx_empty;
            rd_word[STAT_TXFULL]  = tx_full;
         end
         SEL_DATA: if (!rx_empty) rd_word[CHAR_W-1:0] = rx_head;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
   end

   assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> !tx_valid);
   assert_rx_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !rx_ready);
   assert_rst_bits_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_CTRL) |=> (bus_rdata[1:0] == 2'b00));
   assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_DATA && rx_empty) |=> (bus_rdata == '0));
   assert_status_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && sel == SEL_STAT) |=> (bus_rdata[STAT_RXEMPTY] == $past(rx_empty)));
endmodule

// File: tb/test_uart_csr_front.sv
module test_uart_csr_front;
   localparam time CLK_PERIOD = 10ns;
   localparam int  DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_valid = 1'b0;
   logic        rx_ready;
   logic [10:0] line_mode;
   logic [15:0] baud_gen;
   logic [7:0]  baud_div;

   int nchk = 0;
   int nerr = 0;
   logic [7:0] tx_exp[$];
   logic [7:0] rx_exp[$];
   logic [31:0] rd;

   always #(CLK_PERIOD / 2) clk = ~clk;

   uart_csr_front i_uart_csr_front (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .line_mode(line_mode), .baud_gen(baud_gen), .baud_div(baud_div)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string tag);
      logic [31:0] v;
      bus_read(a, v);
      check(v == e, tag, v, e);
   endtask

   // driver: queue the byte in the scoreboard when it should be accepted
   task automatic send_tx(input logic [7:0] b, input bit accepted);
      if (accepted) tx_exp.push_back(b);
      bus_write(8'h30, {24'hABCDEF, b});
   endtask

   task automatic send_rx(input logic [7:0] b);
      rx_data = b; rx_valid = 1'b1;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
      rx_exp.push_back(b);
   endtask

   // monitor: every transmit handshake is compared with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         if (tx_exp.size() == 0) check(1'b0, "R8 unexpected byte", {24'h0, tx_data}, 32'h0);
         else begin
            logic [7:0] e;
            e = tx_exp.pop_front();
            check(tx_data == e, "R8 tx order", {24'h0, tx_data}, {24'h0, e});
         end
      end
   end

   initial begin
      int cyc = 0;
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(!tx_valid && !rx_ready, "R1 streams idle", {tx_valid, rx_ready}, 0);
      check(line_mode == 11'h020, "R1 mode pin", line_mode, 32'h20);
      expect_read(8'h2C, 32'h2, "R1 status");
      expect_read(8'h00, 32'h0, "R1 control");
      expect_read(8'h04, 32'h20, "R1 mode");
      expect_read(8'h18, 32'h28B, "R1 baud gen");
      expect_read(8'h34, 32'h6, "R1 baud div");

      // R10 R11 widths and outputs
      bus_write(8'h04, 32'hFFFF_FFFF);
      expect_read(8'h04, 32'h7FF, "R10 mode width");
      check(line_mode == 11'h7FF, "R10 mode pin", line_mode, 32'h7FF);
      bus_write(8'h04, 32'h20);
      bus_write(8'h18, 32'h1234_ABCD);
      expect_read(8'h18, 32'hABCD, "R11 baud gen width");
      check(baud_gen == 16'hABCD, "R11 baud gen pin", baud_gen, 32'hABCD);
      bus_write(8'h34, 32'h0000_01F3);
      expect_read(8'h34, 32'hF3, "R11 baud div width");
      check(baud_div == 8'hF3, "R11 baud div pin", baud_div, 32'hF3);

      // R2 reserved addresses
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_write(8'h30 + 8'h08, 32'hFFFF_FFFF);
      expect_read(8'h08, 32'h0, "R2 reserved read");
      expect_read(8'h01, 32'h0, "R2 misaligned read");
      expect_read(8'h04, 32'h20, "R2 mode untouched");
      expect_read(8'h00, 32'h0, "R2 control untouched");
      expect_read(8'h34, 32'hF3, "R2 divider untouched");

      // R3 control readback
      bus_write(8'h00, 32'hFFFF_FFFF);
      expect_read(8'h00, 32'h14, "R3 control bits");
      bus_write(8'h00, 32'h0);

      // R6 fill while transmitter disabled, ninth write dropped
      tx_ready = 1'b1;
      for (int i = 0; i < DEPTH + 1; i++) send_tx(8'h40 + 8'(i), i < DEPTH);
      check(!tx_valid, "R8 disabled no offer", tx_valid, 0);
      expect_read(8'h2C, 32'h12, "R5 tx full status");
      bus_write(8'h00, 32'h10);
      repeat (DEPTH + 4) @(negedge clk);
      check(tx_exp.size() == 0, "R6 all bytes drained", tx_exp.size(), 0);
      check(!tx_valid, "R8 idle after drain", tx_valid, 0);
      expect_read(8'h2C, 32'h2, "R5 tx not full");

      // R4 transmit reset with back-pressure, then enable in same word
      tx_ready = 1'b0;
      for (int i = 0; i < 3; i++) send_tx(8'h90 + 8'(i), 1'b0);
      bus_write(8'h00, 32'h12);
      tx_ready = 1'b1;
      repeat (3) @(negedge clk);
      check(!tx_valid, "R4 tx flushed", tx_valid, 0);
      expect_read(8'h00, 32'h10, "R4 tx reset reads 0");
      send_tx(8'h5A, 1'b1);
      repeat (3) @(negedge clk);
      check(tx_exp.size() == 0, "R8 byte after reset", tx_exp.size(), 0);

      // R9 receive gating
      rx_data = 8'h77; rx_valid = 1'b1;
      repeat (2) @(negedge clk);
      check(!rx_ready, "R9 disabled no accept", rx_ready, 0);
      rx_valid = 1'b0;
      expect_read(8'h2C, 32'h2, "R9 nothing stored");
      bus_write(8'h00, 32'h14);

      // R7 order and empty read
      send_rx(8'hA1); send_rx(8'h00); send_rx(8'hFF);
      expect_read(8'h2C, 32'h0, "R5 rx not empty");
      for (int i = 0; i < 3; i++) begin
         logic [7:0] e;
         e = rx_exp.pop_front();
         expect_read(8'h30, {24'h0, e}, "R7 rx order");
      end
      expect_read(8'h30, 32'h0, "R7 empty read zero");
      expect_read(8'h2C, 32'h2, "R7 still empty");

      // R9 full receive FIFO refuses, extra byte lost
      for (int i = 0; i < DEPTH; i++) send_rx(8'hC0 + 8'(i));
      check(!rx_ready, "R9 full no accept", rx_ready, 0);
      rx_data = 8'hEE; rx_valid = 1'b1;
      repeat (3) @(negedge clk);
      rx_valid = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         logic [7:0] e;
         e = rx_exp.pop_front();
         expect_read(8'h30, {24'h0, e}, "R9 stored bytes");
      end
      expect_read(8'h30, 32'h0, "R9 extra byte dropped");

      // R4 receive reset
      send_rx(8'h11); send_rx(8'h22);
      bus_write(8'h00, 32'h05);
      rx_exp.delete();
      expect_read(8'h2C, 32'h2, "R4 rx flushed");
      expect_read(8'h30, 32'h0, "R4 rx reset data");
      expect_read(8'h00, 32'h04, "R4 rx reset reads 0");

      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule